// File: doc/BRIEF.md
# Programmable Baud-Rate Generator Bank

This block holds eight independent baud-rate generators behind one word-wide register port. Each generator owns a 32-bit control word. The word selects a clock source, an optional fixed divide-by-16 prescaler, a 12-bit divide count and an enable bit. A generator produces two outputs: a one-cycle tick that can serve as a clock enable for a serial channel, and a square-wave clock that changes level on every tick.

The clock source is either the system clock or one of two asynchronous external clock pins. Each external pin passes through a two-flop synchroniser, and only its rising edges are counted. The generators are addressed as two groups of four, each group at its own base. A command register lets software clear every control word at once. Software polls a busy flag there until the clearing sweep has finished.

Top module: `brg_bank`

## Requirements
- R1: Generators 0 to 3 sit at word addresses GRP_A_BASE+g (default 0x00 to 0x03). Generators 4 to 7 sit at GRP_B_BASE+(g-4) (default 0x10 to 0x13). A read of a generator address returns all 32 bits last written there.
- R2: A read of any address other than the eight generator words and the command word (default 0x20) returns zero. A write to such an address changes no control word.
- R3: The control word holds the count N in bits 12:1. An enabled generator on the system clock with no prescaler raises its tick output for one cycle every N+1 clock cycles. N=0 gives a tick on every cycle, and N=4095 gives a tick every 4096 cycles.
- R4: Bit 16 is the enable. While it is clear, the generator's tick output and clock output both stay low.
- R5: Bit 0 set places a divide-by-16 stage ahead of the counter, so the tick period becomes 16*(N+1) source events.
- R6: Bits 15:14 pick the source: 00 is the system clock, 01 counts rising edges of ext_clk_a, 10 counts rising edges of ext_clk_b, and 11 selects no source, so no ticks occur.
- R7: A write to a control word reloads that generator's counter and prescaler on the same edge. With the system clock selected, the first tick appears N+1 cycles after the write edge, whatever the old count was.
- R8: The clock output changes level on every tick, so its period is twice the tick period.
- R9: Writing 1 to bit 0 of the command word starts a sweep. The sweep sets the busy flag (bit 0 on read) for eight cycles and clears one control word per cycle. Control writes made while busy is set are ignored. When busy drops, all eight control words read zero.
- R10: After reset, every control word reads zero, busy is clear, and all tick and clock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from addr |
| ext_clk_a | input | 1 | External clock source A, asynchronous |
| ext_clk_b | input | 1 | External clock source B, asynchronous |
| brg_tick | output | 2*GRP_SIZE | One-cycle tick per generator |
| brg_clk | output | 2*GRP_SIZE | Square-wave clock per generator |

## Verification
The divider is driven through a vector table that gives every generator a different combination of count, source and prescaler. Extreme counts of 0 and 4095 show that the counter reaches N+1 exactly and does not stop one short. The prescaled vectors on each source separate a multiply-by-16 from an off-by-one in the counter, because their periods of 48 and 96 cycles cannot come from a count error alone. External sources with periods of 6 and 10 cycles show that each selection reaches the correct pin. Directed cases measure the first tick after a rewrite of a long count, check that the reserved source and a cleared enable stay silent, and confirm that the clear sweep locks out control writes.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 12;
  localparam int CNT_LSB = 1;
  localparam int PRE_BIT = 0;
  localparam int SEL_LSB = 14;
  localparam int EN_BIT  = 16;
  localparam int PRE_DIV = 16;
  localparam int PRE_W   = $clog2(PRE_DIV);

  typedef enum logic [1:0] {
    SRC_SYS   = 2'b00,
    SRC_EXT_A = 2'b01,
    SRC_EXT_B = 2'b10,
    SRC_OFF   = 2'b11
  } brg_src_e;

  typedef struct packed {
    logic             en;
    brg_src_e         src;
    logic             pre16;
    logic [CNT_W-1:0] count;
  } brg_cfg_t;

  function automatic brg_cfg_t brg_unpack(input logic [WORD_W-1:0] w);
    brg_cfg_t c;
    c.en    = w[EN_BIT];
    c.src   = brg_src_e'(w[SEL_LSB +: 2]);
    c.pre16 = w[PRE_BIT];
    c.count = w[CNT_LSB +: CNT_W];
    return c;
  endfunction
endpackage

// File: rtl/brg_sync.sv
module brg_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/brg_regs.sv
module brg_regs #(
  parameter int ADDR_W     = 6,
  parameter int GRP_SIZE   = 4,
  parameter int GRP_A_BASE = 0,
  parameter int GRP_B_BASE = 16,
  parameter int CMD_ADDR   = 32
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       wr_en,
  input  logic [ADDR_W-1:0]                          addr,
  input  logic [brg_pkg::WORD_W-1:0]                 wr_data,
  output logic [brg_pkg::WORD_W-1:0]                 rd_data,
  output logic [2*GRP_SIZE-1:0][brg_pkg::WORD_W-1:0] ctrl_o,
  output logic [2*GRP_SIZE-1:0]                      load_o,
  output logic [brg_pkg::WORD_W-1:0]                 load_word_o,
  output logic                                       hit_o,
  output logic                                       cmd_hit_o,
  output logic                                       busy_o
);
  import brg_pkg::*;

  localparam int NUM_GEN = 2 * GRP_SIZE;
  localparam int IDX_W   = $clog2(NUM_GEN);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(GRP_A_BASE);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(GRP_A_BASE + GRP_SIZE);
  localparam logic [ADDR_W-1:0] B_LO = ADDR_W'(GRP_B_BASE);
  localparam logic [ADDR_W-1:0] B_HI = ADDR_W'(GRP_B_BASE + GRP_SIZE);
  localparam logic [ADDR_W-1:0] C_AD = ADDR_W'(CMD_ADDR);
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(NUM_GEN - 1);

  logic [NUM_GEN-1:0][WORD_W-1:0] ctrl_q;
  logic                           busy_q;
  logic [IDX_W-1:0]               sweep_q;
  logic                           hit;
  logic [IDX_W-1:0]               idx;
  logic                           wr_ok, cmd_go;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (addr >= A_LO && addr < A_HI) begin
      hit = 1'b1;
      idx = IDX_W'(addr - A_LO);
    end else if (addr >= B_LO && addr < B_HI) begin
      hit = 1'b1;
      idx = IDX_W'(addr - B_LO) + IDX_W'(GRP_SIZE);
    end
  end

  assign cmd_hit_o = (addr == C_AD);
  assign hit_o     = hit;
  assign wr_ok     = wr_en & hit & ~busy_q;
  assign cmd_go    = wr_en & cmd_hit_o & wr_data[0] & ~busy_q;

  always_comb begin
    for (int i = 0; i < NUM_GEN; i++) begin
      load_o[i] = (wr_ok && idx == IDX_W'(i)) || (busy_q && sweep_q == IDX_W'(i));
    end
  end

  assign load_word_o = busy_q ? '0 : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      sweep_q <= '0;
    end else begin
      for (int i = 0; i < NUM_GEN; i++) begin
        if (load_o[i]) ctrl_q[i] <= load_word_o;
      end
      if (cmd_go) begin
        busy_q  <= 1'b1;
        sweep_q <= '0;
      end else if (busy_q) begin
        sweep_q <= sweep_q + IDX_W'(1);
        if (sweep_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (hit)            rd_data = ctrl_q[idx];
    else if (cmd_hit_o) rd_data = {{(WORD_W-1){1'b0}}, busy_q};
    else                rd_data = '0;
  end

  assign ctrl_o = ctrl_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/brg_chan.sv
module brg_chan (
  input  logic              clk,
  input  logic              rst_n,
  input  brg_pkg::brg_cfg_t cfg_i,
  input  logic              load_i,
  input  brg_pkg::brg_cfg_t load_cfg_i,
  input  logic [1:0]        ext_rise_i,
  output logic              ptick_o,
  output logic              tick_o,
  output logic              clk_o
);
  import brg_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q, clk_q;
  logic             src_ev, pre_wrap;

  always_comb begin
    case (cfg_i.src)
      SRC_SYS:   src_ev = 1'b1;
      SRC_EXT_A: src_ev = ext_rise_i[0];
      SRC_EXT_B: src_ev = ext_rise_i[1];
      default:   src_ev = 1'b0;
    endcase
  end

  assign pre_wrap = (pre_q == PRE_W'(PRE_DIV - 1));
  assign ptick_o  = src_ev & (~cfg_i.pre16 | pre_wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
      clk_q  <= 1'b0;
    end else if (load_i) begin
      pre_q  <= '0;
      cnt_q  <= load_cfg_i.count;
      tick_q <= 1'b0;
      clk_q  <= 1'b0;
    end else if (!cfg_i.en) begin
      pre_q  <= '0;
      cnt_q  <= cfg_i.count;
      tick_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (src_ev && cfg_i.pre16) pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
      if (ptick_o) begin
        if (cnt_q == '0) begin
          cnt_q  <= cfg_i.count;
          tick_q <= 1'b1;
          clk_q  <= ~clk_q;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign tick_o = tick_q;
  assign clk_o  = clk_q;
endmodule

// File: rtl/brg_bank.sv
module brg_bank #(
  parameter int ADDR_W     = 6,
  parameter int GRP_SIZE   = 4,
  parameter int GRP_A_BASE = 0,
  parameter int GRP_B_BASE = 16,
  parameter int CMD_ADDR   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  input  logic                  ext_clk_a,
  input  logic                  ext_clk_b,
  output logic [2*GRP_SIZE-1:0] brg_tick,
  output logic [2*GRP_SIZE-1:0] brg_clk
);
  import brg_pkg::*;

  localparam int NUM_GEN = 2 * GRP_SIZE;

  logic [NUM_GEN-1:0][WORD_W-1:0] ctrl_w;
  logic [NUM_GEN-1:0]             load_w;
  logic [NUM_GEN-1:0]             ptick_w;
  logic [WORD_W-1:0]              load_word_w;
  logic                           hit_w, cmd_hit_w, busy_w;
  logic [1:0]                     ext_async, ext_rise_w;
  brg_cfg_t                       load_cfg_w;

  assign ext_async  = {ext_clk_b, ext_clk_a};
  assign load_cfg_w = brg_unpack(load_word_w);

  brg_regs #(
    .ADDR_W(ADDR_W), .GRP_SIZE(GRP_SIZE), .GRP_A_BASE(GRP_A_BASE),
    .GRP_B_BASE(GRP_B_BASE), .CMD_ADDR(CMD_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ctrl_o(ctrl_w), .load_o(load_w), .load_word_o(load_word_w),
    .hit_o(hit_w), .cmd_hit_o(cmd_hit_w), .busy_o(busy_w)
  );

  for (genvar e = 0; e < 2; e++) begin : g_sync
    brg_sync u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ext_async[e]), .rise_o(ext_rise_w[e])
    );
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
    brg_cfg_t cfg_g;
    assign cfg_g = brg_unpack(ctrl_w[g]);
    brg_chan u_chan (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg_g), .load_i(load_w[g]),
      .load_cfg_i(load_cfg_w), .ext_rise_i(ext_rise_w),
      .ptick_o(ptick_w[g]), .tick_o(brg_tick[g]), .clk_o(brg_clk[g])
    );
  end
endmodule

// File: rtl/brg_bank_chk.sv
module brg_bank_chk #(
  parameter int NUM_GEN = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [31:0]               wr_data,
  input logic [31:0]               rd_data,
  input logic                      hit,
  input logic                      cmd_hit,
  input logic                      busy,
  input logic [NUM_GEN-1:0][31:0]  ctrl,
  input logic [NUM_GEN-1:0]        ptick,
  input logic [NUM_GEN-1:0]        tick,
  input logic [NUM_GEN-1:0]        bclk
);
  import brg_pkg::*;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    // R4: a disabled word silences both outputs on the next cycle
    p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[g][EN_BIT] |=> (!tick[g] && !bclk[g]));
    // R8: every tick coincides with a level change of the clock output
    p_tick_toggles_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick[g] |-> (bclk[g] != $past(bclk[g])));
    // R6: the reserved source never yields a counter step
    p_off_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[g][SEL_LSB +: 2] == 2'b11) |-> !ptick[g]);
  end

  p_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit && !cmd_hit && !busy) |=> $stable(ctrl));

  p_stray_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !cmd_hit) |-> (rd_data == 32'd0));

  p_busy_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_hit && wr_data[0] && !busy) |=> busy);

  p_sweep_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ctrl == '0));
endmodule

bind brg_bank brg_bank_chk #(.NUM_GEN(NUM_GEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .hit(hit_w), .cmd_hit(cmd_hit_w), .busy(busy_w), .ctrl(ctrl_w),
  .ptick(ptick_w), .tick(brg_tick), .bclk(brg_clk)
);

// File: tb/brg_bank_bench.sv
module brg_bank_bench;
  localparam int ADDR_W = 6;
  localparam int NG     = 8;
  localparam int CMD    = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wr_data = '0;
  logic [31:0]       rd_data;
  logic              ext_clk_a = 1'b0;
  logic              ext_clk_b = 1'b0;
  logic [NG-1:0]     brg_tick, brg_clk;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  brg_bank u_brg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b),
    .brg_tick(brg_tick), .brg_clk(brg_clk)
  );

  always #4 clk = ~clk;
  always #24 ext_clk_a = ~ext_clk_a;
  always #40 ext_clk_b = ~ext_clk_b;

  // Rows: generator, source, count, prescale, expected tick interval in clock cycles
  localparam int VEC [0:7][0:4] = '{
    '{0, 0, 0,    0, 1},
    '{1, 0, 4,    0, 5},
    '{2, 0, 2,    1, 48},
    '{3, 1, 1,    0, 12},
    '{4, 2, 2,    0, 30},
    '{5, 1, 0,    1, 96},
    '{6, 0, 4095, 0, 4096},
    '{7, 0, 9,    0, 10}
  };

  logic [31:0] shadow [NG];

  function automatic logic [ADDR_W-1:0] gen_addr(input int g);
    return (g < 4) ? ADDR_W'(g) : ADDR_W'(16 + g - 4);
  endfunction

  function automatic logic [31:0] make_word(input int en, input int src, input int n, input int p16);
    return (32'(en) << 16) | (32'(src) << 14) | (32'(n) << 1) | 32'(p16);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic measure(input int g, output int interval, output bit toggled);
    int  waited = 0;
    bit  c0;
    interval = -1;
    toggled = 1'b0;
    while (!brg_tick[g] && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    if (!brg_tick[g]) return;
    c0 = brg_clk[g];
    interval = 0;
    do begin
      @(negedge clk);
      interval++;
    end while (!brg_tick[g] && interval < 20000);
    toggled = (brg_clk[g] != c0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int          quiet;
    int          iv;
    bit          tg;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    for (int g = 0; g < NG; g++) begin
      rd(gen_addr(g), d);
      check("R10", "ctrl after reset", d, 32'd0);
    end
    rd(ADDR_W'(CMD), d);
    check("R10", "busy after reset", d, 32'd0);
    quiet = 0;
    repeat (10) begin
      @(negedge clk);
      if (brg_tick != '0 || brg_clk != '0) quiet++;
    end
    check("R10", "outputs idle after reset", 32'(quiet), 32'd0);

    // Vector table: R3 plain count, R5 prescaler, R6 external sources, R8 clock level
    for (int v = 0; v < 8; v++) begin
      string req;
      shadow[VEC[v][0]] = make_word(1, VEC[v][1], VEC[v][2], VEC[v][3]);
      wr(gen_addr(VEC[v][0]), shadow[VEC[v][0]]);
      req = (VEC[v][3] != 0) ? "R5" : ((VEC[v][1] != 0) ? "R6" : "R3");
      measure(VEC[v][0], iv, tg);
      check(req, $sformatf("tick interval gen%0d", VEC[v][0]), 32'(iv), 32'(VEC[v][4]));
      check("R8", $sformatf("clock toggles per tick gen%0d", VEC[v][0]), 32'(tg), 32'd1);
    end

    // R1: readback through both groups, including bits with no function
    shadow[7] = 32'hA5A5_0000 | make_word(1, 0, 9, 0);
    wr(gen_addr(7), shadow[7]);
    for (int g = 0; g < NG; g++) begin
      rd(gen_addr(g), d);
      check("R1", $sformatf("readback gen%0d", g), d, shadow[g]);
    end

    // R2: stray writes and reads
    wr(ADDR_W'(5), 32'hFFFF_FFFF);
    wr(ADDR_W'(20), 32'hFFFF_FFFF);
    wr(ADDR_W'(63), 32'hFFFF_FFFF);
    for (int g = 0; g < NG; g++) begin
      rd(gen_addr(g), d);
      check("R2", $sformatf("unchanged after stray write gen%0d", g), d, shadow[g]);
    end
    rd(ADDR_W'(5), d);  check("R2", "read gap address", d, 32'd0);
    rd(ADDR_W'(20), d); check("R2", "read past group B", d, 32'd0);
    rd(ADDR_W'(63), d); check("R2", "read top address", d, 32'd0);

    // R4: enable clear keeps generator 1 silent
    wr(gen_addr(1), make_word(0, 0, 0, 0));
    quiet = 0;
    repeat (40) begin
      @(negedge clk);
      if (brg_tick[1] || brg_clk[1]) quiet++;
    end
    check("R4", "disabled gen1 outputs", 32'(quiet), 32'd0);

    // R6: reserved source selection produces no ticks
    wr(gen_addr(2), make_word(1, 3, 0, 0));
    quiet = 0;
    repeat (100) begin
      @(negedge clk);
      if (brg_tick[2]) quiet++;
    end
    check("R6", "no ticks with source 11", 32'(quiet), 32'd0);

    // R7: rewrite reloads at once
    wr(gen_addr(0), make_word(1, 0, 200, 0));
    repeat (50) @(negedge clk);
    wr(gen_addr(0), make_word(1, 0, 3, 0));
    iv = 0;
    do begin
      @(negedge clk);
      iv++;
    end while (!brg_tick[0] && iv < 1000);
    check("R7", "first tick after reload", 32'(iv), 32'd4);

    // R9: clear sweep with busy flag and write lockout
    wr(ADDR_W'(CMD), 32'd1);
    rd(ADDR_W'(CMD), d);
    check("R9", "busy set after command", d, 32'd1);
    wr(gen_addr(3), make_word(1, 0, 1, 0));
    repeat (10) @(negedge clk);
    rd(ADDR_W'(CMD), d);
    check("R9", "busy clear after sweep", d, 32'd0);
    for (int g = 0; g < NG; g++) begin
      rd(gen_addr(g), d);
      check("R9", $sformatf("ctrl cleared gen%0d", g), d, 32'd0);
    end
    quiet = 0;
    repeat (20) begin
      @(negedge clk);
      if (brg_tick != '0) quiet++;
    end
    check("R9", "no ticks after sweep", 32'(quiet), 32'd0);

    finish_run();
  end
endmodule